// File: doc/BRIEF.md
# SoC Power Mode Controller

This block watches the run state of every processing subsystem on the chip, together with a flag that says whether any shared resource is still in use, and works out which chip-wide power mode applies. It then drives the clock, regulator, region power, isolation and memory retention controls for that mode. A security controller gives permission for deep low power and picks the depth, either standby or stop. The block walks the chip down into that mode one control step per clock cycle and walks it back up in the reverse order.

Low-power wake lines from the serial ports, comparator, RTC, GPIO, timers and mailbox are forwarded to a destination that depends on the mode. In the full-power modes they go to the application subsystems. In standby they go to the efficiency subsystem only. In stop they go to the security controller only. A wake that arrives while the chip is still on its way down cancels the descent.

Subsystem 0 is the efficiency subsystem and subsystem 1 is the high-performance subsystem. Any further subsystems sit in the performance region.

Top module: `soc_pwr_mode_ctrl`

## Requirements
- R1: Each subsystem reports a 2-bit code: 00 OFF, 01 SLEEP, 10 RUN, 11 treated as RUN. With the chip at full power, `soc_mode` is READY (1) when every subsystem is SLEEP, IDLE (2) when every subsystem is OFF, and GO (0) otherwise. STANDBY is 3 and STOP is 4.
- R2: In GO, READY and IDLE, the PLL, the RC oscillator and both region clocks are enabled, both regions are powered and not isolated, and `reg_mode` is FULL (2). EFFICIENCY is 1 and OFF is 0.
- R3: A power-down starts only when `lp_permit` is high, `shared_busy` is low and every subsystem is OFF. Otherwise the PLL stays enabled.
- R4: Toward standby, the controls change one step per cycle. Step 1 turns off the PLL and the performance clock. Step 2 isolates the performance region. Step 3 removes its power and sets `reg_mode` to EFFICIENCY, and the mode becomes STANDBY. During steps 1 and 2 the mode reads IDLE.
- R5: With `lp_deep` high, the descent continues past standby. Step 4 turns off the RC oscillator and the efficiency clock. Step 5 isolates the efficiency region. Step 6 removes its power and sets `reg_mode` to OFF, and the mode becomes STOP.
- R6: When `lp_permit` falls, when `shared_busy` rises, or when a subsystem other than subsystem 0 leaves OFF, the chip climbs back one step per cycle in the exact reverse order.
- R7: Any wake line that is high while the chip is still below its target depth cancels the descent. The chip returns to full power and stays there until `lp_permit` has been low for at least one cycle.
- R8: From step 3 through step 5, every wake source except the mailbox goes to `wake_eff` only. In steady standby, subsystem 0 may run, and wakes do not restore power to the performance region.
- R9: In STOP, the comparator, RTC, GPIO and timer wakes go to `wake_sec` only. The I2C, UART and mailbox wakes are dropped. Nothing goes to `wake_eff` or `wake_perf`.
- R10: Through step 2, `wake_eff` carries every source. `wake_perf` carries every source, except that I2C and UART are masked while subsystem 1 is OFF. The bit layout of each wake vector is: 0 I2C, 1 UART, 2 comparator, 3 RTC, 4 mailbox, then GPIO 0 upward, then timer 0 upward.
- R11: `eff_mem_pwr` is high through step 2, while subsystem 0 is not OFF, or while `ret_opt` is high. Otherwise it is low.
- R12: Synchronous reset gives GO with all full-power controls and all wake outputs zero.
- R13: Every output is a register. It reflects the inputs sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_state | input | 2*NSS | Per-subsystem state codes, subsystem i at bits 2i+1:2i |
| shared_busy | input | 1 | A shared resource is in use |
| lp_permit | input | 1 | Security controller permits low power |
| lp_deep | input | 1 | Target stop (1) rather than standby (0) |
| ret_opt | input | 1 | Keep efficiency memory powered in low power |
| wk_i2c | input | 1 | Low-power I2C wake |
| wk_uart | input | 1 | Low-power UART wake |
| wk_cmp | input | 1 | Comparator wake |
| wk_rtc | input | 1 | RTC wake |
| wk_mhu | input | 1 | Mailbox wake |
| wk_gpio | input | NGPIO | GPIO wakes |
| wk_tmr | input | NTMR | Timer wakes |
| soc_mode | output | 3 | Chip power mode |
| pll_en | output | 1 | PLL enable |
| hfrc_en | output | 1 | High-frequency RC oscillator enable |
| reg_mode | output | 2 | Regulator mode |
| perf_clk_en | output | 1 | Performance region clock enable |
| perf_iso | output | 1 | Performance region isolation |
| perf_pwr_en | output | 1 | Performance region power enable |
| eff_clk_en | output | 1 | Efficiency region clock enable |
| eff_iso | output | 1 | Efficiency region isolation |
| eff_pwr_en | output | 1 | Efficiency region power enable |
| eff_mem_pwr | output | 1 | Efficiency local memory supply |
| wake_eff | output | 5+NGPIO+NTMR | Wakes routed to subsystem 0 |
| wake_perf | output | 5+NGPIO+NTMR | Wakes routed to subsystem 1 |
| wake_sec | output | 5+NGPIO+NTMR | Wakes routed to the security controller |

## Verification
A wrong depth or a lost cancel flag inside the sequencer shows up at the ports one cycle after the inputs that expose it. It appears as a clock, isolation or power enable in the wrong state, or as a mode code one step off. An ordering fault, such as power removed in the same cycle as isolation, is visible in a single cycle on the enable pairs. A stale cancel flag only appears later, when permission is given again and the PLL still fails to drop. For that reason, permission is dropped and raised again after every cancel. Misrouting is visible on the cycle after a wake is driven, as a bit appearing on the wrong wake vector for the mode just reported.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;

  typedef enum logic [2:0] {
    MODE_GO      = 3'd0,
    MODE_READY   = 3'd1,
    MODE_IDLE    = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_STOP    = 3'd4
  } soc_mode_e;

  typedef enum logic [1:0] {
    REG_OFF  = 2'd0,
    REG_EFF  = 2'd1,
    REG_FULL = 2'd2
  } reg_mode_e;

  localparam logic [1:0] SS_OFF   = 2'b00;
  localparam logic [1:0] SS_SLEEP = 2'b01;

  // power-down depth: each value is one sequencing step
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_ON     = 3'd0;
  localparam logic [LVL_W-1:0] LVL_ISO_HP = 3'd2;
  localparam logic [LVL_W-1:0] LVL_STBY   = 3'd3;
  localparam logic [LVL_W-1:0] LVL_CLK_HE = 3'd4;
  localparam logic [LVL_W-1:0] LVL_ISO_HE = 3'd5;
  localparam logic [LVL_W-1:0] LVL_STOP   = 3'd6;

  typedef struct packed {
    soc_mode_e mode;
    logic      pll_en;
    logic      hfrc_en;
    reg_mode_e regm;
    logic      perf_clk_en;
    logic      perf_iso;
    logic      perf_pwr_en;
    logic      eff_clk_en;
    logic      eff_iso;
    logic      eff_pwr_en;
    logic      eff_mem_pwr;
  } pwr_ctl_t;

endpackage

// File: rtl/spm_state_agg.sv
`timescale 1ns/1ps
module spm_state_agg
  import spm_pkg::*;
#(
  parameter int NSS = 3
) (
  input  logic [2*NSS-1:0] ss_state,
  output logic             all_off,
  output logic             all_sleep,
  output logic             others_off,
  output logic             eff_off,
  output logic             perf_off
);
  logic [NSS-1:0] is_off;
  logic [NSS-1:0] is_sleep;

  for (genvar g = 0; g < NSS; g++) begin : g_ss
    assign is_off[g]   = (ss_state[2*g +: 2] == SS_OFF);
    assign is_sleep[g] = (ss_state[2*g +: 2] == SS_SLEEP);
  end

  assign all_off    = &is_off;
  assign all_sleep  = &is_sleep;
  assign others_off = &is_off[NSS-1:1];
  assign eff_off    = is_off[0];
  assign perf_off   = is_off[1];
endmodule

// File: rtl/spm_seq.sv
`timescale 1ns/1ps
module spm_seq
  import spm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             all_off,
  input  logic             others_off,
  input  logic             shared_busy,
  input  logic             lp_permit,
  input  logic             lp_deep,
  input  logic             any_wake,
  output logic [LVL_W-1:0] lvl_nxt
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] goal_raw;
  logic [LVL_W-1:0] goal;
  logic             abort_q;
  logic             abort_d;
  logic             cancel;

  always_comb begin
    if (!lp_permit || shared_busy || abort_q || !others_off)
      goal_raw = LVL_ON;
    else if (all_off)
      goal_raw = lp_deep ? LVL_STOP : LVL_STBY;
    else if (lvl_q != LVL_ON)
      goal_raw = LVL_STBY;   // efficiency subsystem may run in standby
    else
      goal_raw = LVL_ON;

    cancel  = any_wake && (lvl_q < goal_raw);
    goal    = cancel ? LVL_ON : goal_raw;
    abort_d = lp_permit && (abort_q || cancel);

    if (lvl_q < goal)      lvl_nxt = lvl_q + LVL_W'(1);
    else if (lvl_q > goal) lvl_nxt = lvl_q - LVL_W'(1);
    else                   lvl_nxt = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= LVL_ON;
      abort_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_nxt;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/spm_ctl_dec.sv
`timescale 1ns/1ps
module spm_ctl_dec
  import spm_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  logic             all_off,
  input  logic             all_sleep,
  input  logic             eff_off,
  input  logic             ret_opt,
  output pwr_ctl_t         ctl
);
  always_comb begin
    ctl.pll_en      = (lvl == LVL_ON);
    ctl.perf_clk_en = (lvl == LVL_ON);
    ctl.perf_iso    = (lvl >= LVL_ISO_HP);
    ctl.perf_pwr_en = (lvl < LVL_STBY);
    ctl.hfrc_en     = (lvl < LVL_CLK_HE);
    ctl.eff_clk_en  = (lvl < LVL_CLK_HE);
    ctl.eff_iso     = (lvl >= LVL_ISO_HE);
    ctl.eff_pwr_en  = (lvl < LVL_STOP);
    ctl.eff_mem_pwr = (lvl < LVL_STBY) || ret_opt || !eff_off;

    if (lvl < LVL_STBY)      ctl.regm = REG_FULL;
    else if (lvl < LVL_STOP) ctl.regm = REG_EFF;
    else                     ctl.regm = REG_OFF;

    if (lvl == LVL_ON) begin
      if (all_sleep)    ctl.mode = MODE_READY;
      else if (all_off) ctl.mode = MODE_IDLE;
      else              ctl.mode = MODE_GO;
    end else if (lvl < LVL_STBY) begin
      ctl.mode = MODE_IDLE;
    end else if (lvl < LVL_STOP) begin
      ctl.mode = MODE_STANDBY;
    end else begin
      ctl.mode = MODE_STOP;
    end
  end
endmodule

// File: rtl/spm_wake_route.sv
`timescale 1ns/1ps
module spm_wake_route
  import spm_pkg::*;
#(
  parameter int W = 17
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic             perf_off,
  input  logic [W-1:0]     src,
  output logic [W-1:0]     to_eff,
  output logic [W-1:0]     to_perf,
  output logic [W-1:0]     to_sec
);
  localparam logic [W-1:0] M_SER  = W'(3);    // I2C, UART
  localparam logic [W-1:0] M_MBX  = W'(16);   // mailbox
  localparam logic [W-1:0] M_STOP = ~(M_SER | M_MBX);

  always_comb begin
    to_eff  = '0;
    to_perf = '0;
    to_sec  = '0;
    if (lvl == LVL_STOP) begin
      to_sec = src & M_STOP;
    end else if (lvl >= LVL_STBY) begin
      to_eff = src & ~M_MBX;
    end else begin
      to_eff  = src;
      to_perf = perf_off ? (src & ~M_SER) : src;
    end
  end
endmodule

// File: rtl/soc_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module soc_pwr_mode_ctrl
  import spm_pkg::*;
#(
  parameter int NSS   = 3,
  parameter int NGPIO = 8,
  parameter int NTMR  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2*NSS-1:0]          ss_state,
  input  logic                      shared_busy,
  input  logic                      lp_permit,
  input  logic                      lp_deep,
  input  logic                      ret_opt,
  input  logic                      wk_i2c,
  input  logic                      wk_uart,
  input  logic                      wk_cmp,
  input  logic                      wk_rtc,
  input  logic                      wk_mhu,
  input  logic [NGPIO-1:0]          wk_gpio,
  input  logic [NTMR-1:0]           wk_tmr,
  output logic [2:0]                soc_mode,
  output logic                      pll_en,
  output logic                      hfrc_en,
  output logic [1:0]                reg_mode,
  output logic                      perf_clk_en,
  output logic                      perf_iso,
  output logic                      perf_pwr_en,
  output logic                      eff_clk_en,
  output logic                      eff_iso,
  output logic                      eff_pwr_en,
  output logic                      eff_mem_pwr,
  output logic [5+NGPIO+NTMR-1:0]   wake_eff,
  output logic [5+NGPIO+NTMR-1:0]   wake_perf,
  output logic [5+NGPIO+NTMR-1:0]   wake_sec
);
  localparam int NWK = 5 + NGPIO + NTMR;
  localparam pwr_ctl_t CTL_RST = '{
    mode: MODE_GO, pll_en: 1'b1, hfrc_en: 1'b1, regm: REG_FULL,
    perf_clk_en: 1'b1, perf_iso: 1'b0, perf_pwr_en: 1'b1,
    eff_clk_en: 1'b1, eff_iso: 1'b0, eff_pwr_en: 1'b1, eff_mem_pwr: 1'b1};

  logic             all_off, all_sleep, others_off, eff_off, perf_off;
  logic [LVL_W-1:0] lvl_nxt;
  logic [NWK-1:0]   wk_src, r_eff, r_perf, r_sec;
  pwr_ctl_t         ctl_d, ctl_q;

  assign wk_src = {wk_tmr, wk_gpio, wk_mhu, wk_rtc, wk_cmp, wk_uart, wk_i2c};

  spm_state_agg #(.NSS(NSS)) u_agg (
    .ss_state   (ss_state),
    .all_off    (all_off),
    .all_sleep  (all_sleep),
    .others_off (others_off),
    .eff_off    (eff_off),
    .perf_off   (perf_off)
  );

  spm_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .all_off     (all_off),
    .others_off  (others_off),
    .shared_busy (shared_busy),
    .lp_permit   (lp_permit),
    .lp_deep     (lp_deep),
    .any_wake    (|wk_src),
    .lvl_nxt     (lvl_nxt)
  );

  spm_ctl_dec u_dec (
    .lvl       (lvl_nxt),
    .all_off   (all_off),
    .all_sleep (all_sleep),
    .eff_off   (eff_off),
    .ret_opt   (ret_opt),
    .ctl       (ctl_d)
  );

  spm_wake_route #(.W(NWK)) u_route (
    .lvl      (lvl_nxt),
    .perf_off (perf_off),
    .src      (wk_src),
    .to_eff   (r_eff),
    .to_perf  (r_perf),
    .to_sec   (r_sec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= CTL_RST;
      wake_eff  <= '0;
      wake_perf <= '0;
      wake_sec  <= '0;
    end else begin
      ctl_q     <= ctl_d;
      wake_eff  <= r_eff;
      wake_perf <= r_perf;
      wake_sec  <= r_sec;
    end
  end

  assign soc_mode    = ctl_q.mode;
  assign pll_en      = ctl_q.pll_en;
  assign hfrc_en     = ctl_q.hfrc_en;
  assign reg_mode    = ctl_q.regm;
  assign perf_clk_en = ctl_q.perf_clk_en;
  assign perf_iso    = ctl_q.perf_iso;
  assign perf_pwr_en = ctl_q.perf_pwr_en;
  assign eff_clk_en  = ctl_q.eff_clk_en;
  assign eff_iso     = ctl_q.eff_iso;
  assign eff_pwr_en  = ctl_q.eff_pwr_en;
  assign eff_mem_pwr = ctl_q.eff_mem_pwr;
endmodule

// File: rtl/spm_checks.sv
`timescale 1ns/1ps
module spm_checks #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst,
  input logic         lp_permit,
  input logic         shared_busy,
  input logic [2:0]   soc_mode,
  input logic         pll_en,
  input logic         hfrc_en,
  input logic [1:0]   reg_mode,
  input logic         perf_clk_en,
  input logic         perf_iso,
  input logic         perf_pwr_en,
  input logic         eff_clk_en,
  input logic         eff_iso,
  input logic         eff_pwr_en,
  input logic [W-1:0] wake_eff,
  input logic [W-1:0] wake_perf,
  input logic [W-1:0] wake_sec
);
  // R3
  entry_permit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en) |-> $past(lp_permit && !shared_busy));
  // R4
  perf_clk_before_iso_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(perf_iso) |-> $past(!perf_clk_en));
  // R4
  perf_iso_before_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(perf_pwr_en) |-> $past(perf_iso));
  // R5
  eff_clk_before_iso_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eff_iso) |-> $past(!eff_clk_en));
  // R5
  eff_iso_before_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eff_pwr_en) |-> $past(eff_iso));
  // R6
  perf_on_before_deiso_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(perf_iso) |-> $past(perf_pwr_en));
  // R6
  eff_on_before_deiso_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eff_iso) |-> $past(eff_pwr_en));
  // R5
  stop_supplies_chk: assert property (@(posedge clk) disable iff (rst)
    (soc_mode == 3'd4) |-> (reg_mode == 2'd0 && !hfrc_en));
  // R9
  stop_routing_chk: assert property (@(posedge clk) disable iff (rst)
    (soc_mode == 3'd4) |-> (wake_eff == '0 && wake_perf == '0));
  // R9
  sec_only_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_sec != '0) |-> (soc_mode == 3'd4));
  // R8
  perf_dark_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    !perf_pwr_en |-> (wake_perf == '0));
endmodule

bind soc_pwr_mode_ctrl spm_checks #(.W(NWK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lp_permit   (lp_permit),
  .shared_busy (shared_busy),
  .soc_mode    (soc_mode),
  .pll_en      (pll_en),
  .hfrc_en     (hfrc_en),
  .reg_mode    (reg_mode),
  .perf_clk_en (perf_clk_en),
  .perf_iso    (perf_iso),
  .perf_pwr_en (perf_pwr_en),
  .eff_clk_en  (eff_clk_en),
  .eff_iso     (eff_iso),
  .eff_pwr_en  (eff_pwr_en),
  .wake_eff    (wake_eff),
  .wake_perf   (wake_perf),
  .wake_sec    (wake_sec)
);

// File: tb/sim_soc_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_soc_pwr_mode_ctrl;
  localparam int NSS = 3, NGPIO = 8, NTMR = 4, NWK = 5 + NGPIO + NTMR;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [2*NSS-1:0] ss;
  logic busy, permit, deep, ret;
  logic wi2c, wuart, wcmp, wrtc, wmhu;
  logic [NGPIO-1:0] wgpio;
  logic [NTMR-1:0] wtmr;
  logic [2:0] soc_mode;
  logic [1:0] reg_mode;
  logic pll_en, hfrc_en, perf_clk_en, perf_iso, perf_pwr_en;
  logic eff_clk_en, eff_iso, eff_pwr_en, eff_mem_pwr;
  logic [NWK-1:0] wake_eff, wake_perf, wake_sec;

  soc_pwr_mode_ctrl #(.NSS(NSS), .NGPIO(NGPIO), .NTMR(NTMR)) u0 (
    .clk(clk), .rst(rst), .ss_state(ss), .shared_busy(busy), .lp_permit(permit),
    .lp_deep(deep), .ret_opt(ret), .wk_i2c(wi2c), .wk_uart(wuart), .wk_cmp(wcmp),
    .wk_rtc(wrtc), .wk_mhu(wmhu), .wk_gpio(wgpio), .wk_tmr(wtmr),
    .soc_mode(soc_mode), .pll_en(pll_en), .hfrc_en(hfrc_en), .reg_mode(reg_mode),
    .perf_clk_en(perf_clk_en), .perf_iso(perf_iso), .perf_pwr_en(perf_pwr_en),
    .eff_clk_en(eff_clk_en), .eff_iso(eff_iso), .eff_pwr_en(eff_pwr_en),
    .eff_mem_pwr(eff_mem_pwr), .wake_eff(wake_eff), .wake_perf(wake_perf),
    .wake_sec(wake_sec));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_lvl, m_abort;
  int e_mode, e_pll, e_hfrc, e_reg, e_pclk, e_piso, e_ppwr, e_eclk, e_eiso, e_epwr, e_mem;
  logic [NWK-1:0] e_weff, e_wperf, e_wsec;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NWK-1:0] src_vec();
    return {wtmr, wgpio, wmhu, wrtc, wcmp, wuart, wi2c};
  endfunction

  task automatic model_step();
    bit all_off, others_off, all_sleep, cancel;
    int g, L;
    logic [NWK-1:0] s;
    all_off = (ss == '0);
    others_off = (ss[2*NSS-1:2] == '0);
    all_sleep = 1'b1;
    for (int i = 0; i < NSS; i++) if (ss[2*i +: 2] != 2'b01) all_sleep = 1'b0;
    s = src_vec();
    if (!permit || busy || m_abort != 0 || !others_off) g = 0;
    else if (all_off) g = deep ? 6 : 3;
    else g = (m_lvl != 0) ? 3 : 0;
    cancel = (s != '0) && (m_lvl < g);
    if (cancel) g = 0;
    m_abort = (permit && (m_abort != 0 || cancel)) ? 1 : 0;
    if (m_lvl < g) m_lvl++;
    else if (m_lvl > g) m_lvl--;
    L = m_lvl;
    e_mode = (L == 0) ? (all_sleep ? 1 : all_off ? 2 : 0) : (L < 3) ? 2 : (L < 6) ? 3 : 4;
    e_pll = (L == 0); e_pclk = (L == 0); e_piso = (L >= 2); e_ppwr = (L < 3);
    e_hfrc = (L < 4); e_eclk = (L < 4); e_eiso = (L >= 5); e_epwr = (L < 6);
    e_reg = (L < 3) ? 2 : (L < 6) ? 1 : 0;
    e_mem = (L < 3 || ret || ss[1:0] != 2'b00) ? 1 : 0;
    e_weff = '0; e_wperf = '0; e_wsec = '0;
    if (L == 6) e_wsec = s & ~NWK'(19);
    else if (L >= 3) e_weff = s & ~NWK'(16);
    else begin
      e_weff = s;
      e_wperf = (ss[3:2] == 2'b00) ? (s & ~NWK'(3)) : s;
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "mode", soc_mode, e_mode);
    chk(tag, "pll_en", pll_en, e_pll);
    chk(tag, "hfrc_en", hfrc_en, e_hfrc);
    chk(tag, "reg_mode", reg_mode, e_reg);
    chk(tag, "perf_clk_en", perf_clk_en, e_pclk);
    chk(tag, "perf_iso", perf_iso, e_piso);
    chk(tag, "perf_pwr_en", perf_pwr_en, e_ppwr);
    chk(tag, "eff_clk_en", eff_clk_en, e_eclk);
    chk(tag, "eff_iso", eff_iso, e_eiso);
    chk(tag, "eff_pwr_en", eff_pwr_en, e_epwr);
    chk(tag, "eff_mem_pwr", eff_mem_pwr, e_mem);
    chk(tag, "wake_eff", int'(wake_eff), int'(e_weff));
    chk(tag, "wake_perf", int'(wake_perf), int'(e_wperf));
    chk(tag, "wake_sec", int'(wake_sec), int'(e_wsec));
  endtask

  // R13: outputs follow the inputs of the preceding edge
  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic no_wake();
    wi2c = 0; wuart = 0; wcmp = 0; wrtc = 0; wmhu = 0; wgpio = '0; wtmr = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst = 1; ss = 6'b101010; busy = 0; permit = 1; deep = 1; ret = 0;
    no_wake(); wgpio = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12", "mode", soc_mode, 0);
    chk("R12", "pll_en", pll_en, 1);
    chk("R12", "reg_mode", reg_mode, 2);
    chk("R12", "perf_pwr_en", perf_pwr_en, 1);
    chk("R12", "eff_iso", eff_iso, 0);
    chk("R12", "wake_eff", int'(wake_eff), 0);
    m_lvl = 0; m_abort = 0;
    no_wake(); permit = 0; deep = 0;
    rst = 0;

    // R1 / R2 mode derivation at full power
    tick("R1 all run");
    chk("R1", "mode go", soc_mode, 0);
    chk("R2", "hfrc_en", hfrc_en, 1);
    chk("R2", "eff_clk_en", eff_clk_en, 1);
    ss = 6'b00_01_10; tick("R1 mixed");
    chk("R1", "mode mixed", soc_mode, 0);
    ss = 6'b01_01_01; tick("R1 all sleep");
    chk("R1", "mode ready", soc_mode, 1);
    ss = 6'b11_01_01; tick("R1 code3");
    chk("R1", "mode code3 go", soc_mode, 0);
    ss = '0; tick("R1 all off");
    chk("R1", "mode idle", soc_mode, 2);
    chk("R2", "reg full", reg_mode, 2);

    // R10 routing at full power
    wi2c = 1; wmhu = 1; tick("R10 perf off");
    chk("R10", "eff gets i2c+mbx", int'(wake_eff), 17);
    chk("R10", "perf masks i2c", int'(wake_perf), 16);
    ss = 6'b00_01_00; wmhu = 0; tick("R10 perf sleep");
    chk("R10", "perf gets i2c", int'(wake_perf), 1);
    no_wake(); ss = '0;

    // R3 entry conditions
    busy = 1; permit = 1;
    repeat (3) tick("R3 busy");
    chk("R3", "pll busy", pll_en, 1);
    busy = 0; ss = 6'b00_01_00;
    repeat (2) tick("R3 not all off");
    chk("R3", "pll not off", pll_en, 1);
    ss = '0;

    // R4 standby descent
    tick("R4 step1");
    chk("R4", "pll off", pll_en, 0);
    chk("R4", "iso not yet", perf_iso, 0);
    chk("R4", "mode idle", soc_mode, 2);
    tick("R4 step2");
    chk("R4", "iso on", perf_iso, 1);
    chk("R4", "power still on", perf_pwr_en, 1);
    tick("R4 step3");
    chk("R4", "power off", perf_pwr_en, 0);
    chk("R4", "reg eff", reg_mode, 1);
    chk("R4", "mode standby", soc_mode, 3);
    tick("R4 hold");
    chk("R11", "mem off no ret", eff_mem_pwr, 0);

    // R8 wake in steady standby while efficiency subsystem runs
    ss = 6'b00_00_10; wgpio = 8'h01; wmhu = 1;
    tick("R8 standby wake");
    chk("R8", "eff gets gpio0", int'(wake_eff), 32);
    chk("R8", "perf none", int'(wake_perf), 0);
    chk("R11", "mem on eff running", eff_mem_pwr, 1);
    no_wake();
    repeat (3) tick("R8 stays");
    chk("R8", "perf still dark", perf_pwr_en, 0);
    chk("R8", "still standby", soc_mode, 3);

    // R5 deeper to stop
    ss = '0; deep = 1; ret = 1;
    tick("R5 step4");
    chk("R5", "hfrc off", hfrc_en, 0);
    chk("R5", "eff clk off", eff_clk_en, 0);
    tick("R5 step5");
    chk("R5", "eff iso", eff_iso, 1);
    tick("R5 step6");
    chk("R5", "eff power off", eff_pwr_en, 0);
    chk("R5", "reg off", reg_mode, 0);
    chk("R5", "mode stop", soc_mode, 4);
    chk("R11", "mem retained", eff_mem_pwr, 1);
    ret = 0; tick("R11 drop ret");
    chk("R11", "mem off", eff_mem_pwr, 0);

    // R9 stop routing
    wgpio = 8'h80; wuart = 1; tick("R9 stop wake");
    chk("R9", "sec gets gpio7", int'(wake_sec), 4096);
    chk("R9", "eff none", int'(wake_eff), 0);
    chk("R9", "still stop", soc_mode, 4);
    no_wake();

    // R6 reverse climb
    permit = 0;
    tick("R6 up1");
    chk("R6", "eff power back", eff_pwr_en, 1);
    chk("R6", "eff still iso", eff_iso, 1);
    tick("R6 up2");
    chk("R6", "eff deiso", eff_iso, 0);
    chk("R6", "eff clk still off", eff_clk_en, 0);
    tick("R6 up3");
    chk("R6", "hfrc back", hfrc_en, 1);
    tick("R6 up4");
    chk("R6", "perf power back", perf_pwr_en, 1);
    chk("R6", "perf still iso", perf_iso, 1);
    tick("R6 up5");
    chk("R6", "perf deiso", perf_iso, 0);
    chk("R6", "pll still off", pll_en, 0);
    tick("R6 up6");
    chk("R6", "pll back", pll_en, 1);

    // R7 cancel during descent
    permit = 1; deep = 1;
    tick("R7 start");
    chk("R7", "pll off", pll_en, 0);
    wrtc = 1; tick("R7 cancel");
    chk("R7", "pll back", pll_en, 1);
    no_wake();
    repeat (3) tick("R7 held");
    chk("R7", "stays up", pll_en, 1);
    permit = 0; tick("R7 clear");
    permit = 1; tick("R7 again");
    chk("R7", "descends again", pll_en, 0);
    permit = 0;
    repeat (2) tick("R7 restore");

    // random mix
    for (int c = 0; c < 5000; c++) begin
      if ($urandom % 10 == 0) begin
        if ($urandom % 4 != 0) ss = '0;
        else for (int i = 0; i < NSS; i++) ss[2*i +: 2] = 2'($urandom % 4);
        busy = ($urandom % 8 == 0);
        permit = ($urandom % 6 != 0);
        deep = $urandom % 2;
        ret = $urandom % 2;
      end
      no_wake();
      if ($urandom % 12 == 0) begin
        int b;
        b = $urandom % NWK;
        if (b == 0) wi2c = 1;
        else if (b == 1) wuart = 1;
        else if (b == 2) wcmp = 1;
        else if (b == 3) wrtc = 1;
        else if (b == 4) wmhu = 1;
        else if (b < 5 + NGPIO) wgpio[b-5] = 1'b1;
        else wtmr[b-5-NGPIO] = 1'b1;
      end
      tick("R3 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule